// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the byte-wide register side of a serial port. A simple bus with an address, write data, write and read strobes, and read data reaches a set of enable, control, frame-format, baud-divisor and FIFO-setup registers. Behind the bus sit a sixteen-entry transmit queue and a sixteen-entry receive queue. Each receive entry keeps its character together with the parity, framing and overrun flags that the deserializer reported. The shift logic is outside the block. The transmit side hands bytes out through a valid/pop handshake. The receive side accepts one character with its error flags on each push pulse. The block drives the frame format, the direction enables and the 16-bit divisor to the shift logic. One bit time is 16 × (divisor + 1) clocks.

Software reads the data register to take the oldest received character. The line status register then shows the error flags of that character. Two interrupt flags exist, transmit and receive. Hardware conditions raise them. Software can raise them through a set register and drop them through a separate clear register. The interrupt line is high while any enabled flag is high. The receive flag fires only when the receive fill level is above half the queue plus a 3-bit threshold, so it cannot be set to fire below half full.

Top module: `sioRegUnit`

## Requirements
- R1: After reset every register reads 0, except as follows. FIFO status at 0x0A reads 0x84, because the receive queue is empty (bit 2) and the transmit queue holds 4 or fewer entries (bit 7). Line status at 0x02 reads 0x40 while txBusy is low. The interrupt status at 0x1F shows only the transmit flag (0x01). irq is low.
- R2: The frame register at 0x03 keeps bits 0 (8-bit characters), 1 (two stop bits), 2 (parity on) and 4 (odd parity) and drives them out; its other bits read 0. Control at 0x01 keeps receive enable in bit 0 and transmit enable in bit 1. The divisor low byte at 0x08 and high byte at 0x09 form baudDiv.
- R3: A write to the data register at 0x04 appends to the transmit queue, and a write to a full queue is dropped. FIFO status bit 4 reports full. txValid is high only when the global enable (0x00 bit 0), the transmit enable and a non-empty queue are all present. txData is the oldest entry, and txPop removes it.
- R4: When the mode bit of a queue is clear, that queue holds at most one entry. The transmit mode bit is bit 7 of 0x0B and the receive mode bit is bit 3. With the bit set, the queue holds 16 entries.
- R5: rxPush stores a character only while the global enable and the receive enable are set. A read of 0x04 returns the oldest character and removes it. After that read, line status bits 0, 1 and 2 show that character's parity, framing and overrun flags.
- R6: A receive push into a full queue is discarded. The overrun flag is then set on the newest stored entry.
- R7: FIFO status bit 3 and the receive interrupt condition are true when the receive count exceeds 8 plus the threshold in bits 2:0 of 0x0B.
- R8: The transmit interrupt flag (bit 0) is set, and FIFO status bit 7 reads 1, whenever the transmit queue holds 4 or fewer entries.
- R9: Writing a 1 to a bit of 0x1D raises that flag, and writing a 1 to a bit of 0x1C lowers it. The transmit flag is bit 0 and the receive flag is bit 1. When a hardware condition holds in the same cycle as a clear, the flag stays set.
- R10: 0x1F shows the flags. irq is the OR of the flags masked by the enables in 0x1E.
- R11: Writing control bit 2 empties both queues and clears the latched error flags. That bit reads back 0, and the other control bits take the written value.
- R12: Line status bit 6 is 1 only when the transmit queue is empty and txBusy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register byte offset |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (a read of 0x04 removes an entry) |
| busRdata | output | 8 | Read data, combinational from busAddr |
| txValid | output | 1 | Transmit byte available to the serializer |
| txData | output | 8 | Oldest transmit byte |
| txPop | input | 1 | Serializer takes txData |
| txBusy | input | 1 | Serializer shifter still sending |
| rxPush | input | 1 | Deserializer delivers a character |
| rxData | input | 8 | Received character |
| rxParErr | input | 1 | Parity error of the character |
| rxFrmErr | input | 1 | Framing error of the character |
| rxOvrErr | input | 1 | Overrun seen by the deserializer |
| cfgEightBit | output | 1 | 8-bit characters when high, 7-bit when low |
| cfgTwoStop | output | 1 | Two stop bits |
| cfgParityOn | output | 1 | Parity enabled |
| cfgParityOdd | output | 1 | Odd parity |
| cfgRxOn | output | 1 | Receiver enabled |
| cfgTxOn | output | 1 | Transmitter enabled |
| baudDiv | output | 16 | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
Random transmit bytes are written past the capacity of the queue and then popped, which shows both the ordering and the dropping of the surplus writes. Random receive characters carry random error flags, and the line status is read after each data read, so the per-character error flags cannot be confused with flags latched for the queue as a whole. Directed sequences step the receive fill across 8 + threshold for two threshold values and push past a full queue, which separates the above-threshold test from an at-threshold test and shows where the overrun mark lands. Clearing a flag while its hardware condition holds, and running each queue in single-entry mode, cover the priority rule and the mode bits.

// File: rtl/sioPkg.sv
package sioPkg;
  localparam int REG_W = 8;

  localparam int OFS_ENABLE   = 'h00;
  localparam int OFS_CONTROL  = 'h01;
  localparam int OFS_LINE     = 'h02;
  localparam int OFS_FRAME    = 'h03;
  localparam int OFS_DATA     = 'h04;
  localparam int OFS_DIV_LO   = 'h08;
  localparam int OFS_DIV_HI   = 'h09;
  localparam int OFS_FSTAT    = 'h0A;
  localparam int OFS_FCFG     = 'h0B;
  localparam int OFS_FLAG_CLR = 'h1C;
  localparam int OFS_FLAG_SET = 'h1D;
  localparam int OFS_INT_EN   = 'h1E;
  localparam int OFS_INT_STAT = 'h1F;

  // entry layout of the receive queue: {overrun, framing, parity, data}
  localparam int RX_ENTRY_W = REG_W + 3;
  localparam int RX_OVR_BIT = REG_W + 2;

  typedef struct packed {
    logic wrEnable;
    logic wrControl;
    logic wrFrame;
    logic wrData;
    logic wrDivLo;
    logic wrDivHi;
    logic wrFifoCfg;
    logic wrFlagClr;
    logic wrFlagSet;
    logic wrIntEn;
    logic rdData;
  } strobes_t;

  typedef struct packed {
    logic [REG_W-1:0] enable;
    logic [REG_W-1:0] control;
    logic [REG_W-1:0] line;
    logic [REG_W-1:0] frame;
    logic [REG_W-1:0] divLo;
    logic [REG_W-1:0] divHi;
    logic [REG_W-1:0] fifoStat;
    logic [REG_W-1:0] fifoCfg;
    logic [REG_W-1:0] intEn;
    logic [REG_W-1:0] intStat;
    logic [REG_W-1:0] rxHead;
  } regView_t;
endpackage

// File: rtl/sioFifo.sv
module sioFifo #(
  parameter int WIDTH    = 8,
  parameter int DEPTH    = 16,
  parameter int MARK_BIT = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             pushData,
  input  logic                         pop,
  input  logic                         markLast,
  output logic [WIDTH-1:0]             headData,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, lastPtr;

  always_comb lastPtr = wrPtr - PTR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= rdPtr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (push)          mem[wrPtr] <= pushData;
      else if (markLast) mem[lastPtr][MARK_BIT] <= 1'b1;
    end
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/sioCtrl.sv
module sioCtrl
  import sioPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  regView_t          view,
  output strobes_t          strb,
  output logic [REG_W-1:0]  busRdata
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    strb           = '0;
    strb.wrEnable  = busWe && hit(busAddr, OFS_ENABLE);
    strb.wrControl = busWe && hit(busAddr, OFS_CONTROL);
    strb.wrFrame   = busWe && hit(busAddr, OFS_FRAME);
    strb.wrData    = busWe && hit(busAddr, OFS_DATA);
    strb.wrDivLo   = busWe && hit(busAddr, OFS_DIV_LO);
    strb.wrDivHi   = busWe && hit(busAddr, OFS_DIV_HI);
    strb.wrFifoCfg = busWe && hit(busAddr, OFS_FCFG);
    strb.wrFlagClr = busWe && hit(busAddr, OFS_FLAG_CLR);
    strb.wrFlagSet = busWe && hit(busAddr, OFS_FLAG_SET);
    strb.wrIntEn   = busWe && hit(busAddr, OFS_INT_EN);
    strb.rdData    = busRe && hit(busAddr, OFS_DATA);
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      case (int'(busAddr))
        OFS_ENABLE:   busRdata = view.enable;
        OFS_CONTROL:  busRdata = view.control;
        OFS_LINE:     busRdata = view.line;
        OFS_FRAME:    busRdata = view.frame;
        OFS_DATA:     busRdata = view.rxHead;
        OFS_DIV_LO:   busRdata = view.divLo;
        OFS_DIV_HI:   busRdata = view.divHi;
        OFS_FSTAT:    busRdata = view.fifoStat;
        OFS_FCFG:     busRdata = view.fifoCfg;
        OFS_INT_EN:   busRdata = view.intEn;
        OFS_INT_STAT: busRdata = view.intStat;
        default:      busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sioDatapath.sv
module sioDatapath
  import sioPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TX_LOW = 4,
  parameter int N_FLAG = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    strb,
  input  logic [REG_W-1:0]            wdata,
  input  logic                        txPop,
  input  logic                        txBusy,
  input  logic                        rxPush,
  input  logic [REG_W-1:0]            rxData,
  input  logic                        rxParErr,
  input  logic                        rxFrmErr,
  input  logic                        rxOvrErr,
  output regView_t                    view,
  output logic                        txValid,
  output logic [REG_W-1:0]            txData,
  output logic                        cfgEightBit,
  output logic                        cfgTwoStop,
  output logic                        cfgParityOn,
  output logic                        cfgParityOdd,
  output logic                        cfgRxOn,
  output logic                        cfgTxOn,
  output logic [2*REG_W-1:0]          baudDiv,
  output logic                        irq,
  output logic [$clog2(DEPTH+1)-1:0]  txCount,
  output logic [$clog2(DEPTH+1)-1:0]  rxCount,
  output logic [N_FLAG-1:0]           flags
);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int HALF   = DEPTH / 2;
  localparam int FLAG_TX = 0;
  localparam int FLAG_RX = 1;

  logic             globalOn, rxOn, txOn;
  logic             frEight, frTwoStop, frParOn, frParOdd;
  logic [REG_W-1:0] divLo, divHi;
  logic [2:0]       rxThresh;
  logic             rxFifoMode, txFifoMode;
  logic [2:0]       errLatch;
  logic [N_FLAG-1:0] intEn;

  logic             txFull, rxFull, txLowHit, rxHit, rxEmpty, txIdle;
  logic             txPushOk, txPopOk, rxAccept, rxPushOk, rxMark, rxPopOk, flush;
  logic [RX_ENTRY_W-1:0] rxHeadEntry;
  logic [N_FLAG-1:0] hwSet, swSet, swClr;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalOn   <= 1'b0;
      rxOn       <= 1'b0;
      txOn       <= 1'b0;
      frEight    <= 1'b0;
      frTwoStop  <= 1'b0;
      frParOn    <= 1'b0;
      frParOdd   <= 1'b0;
      divLo      <= '0;
      divHi      <= '0;
      rxThresh   <= '0;
      rxFifoMode <= 1'b0;
      txFifoMode <= 1'b0;
      intEn      <= '0;
    end else begin
      if (strb.wrEnable) globalOn <= wdata[0];
      if (strb.wrControl) begin
        rxOn <= wdata[0];
        txOn <= wdata[1];
      end
      if (strb.wrFrame) begin
        frEight   <= wdata[0];
        frTwoStop <= wdata[1];
        frParOn   <= wdata[2];
        frParOdd  <= wdata[4];
      end
      if (strb.wrDivLo) divLo <= wdata;
      if (strb.wrDivHi) divHi <= wdata;
      if (strb.wrFifoCfg) begin
        rxThresh   <= wdata[2:0];
        rxFifoMode <= wdata[3];
        txFifoMode <= wdata[7];
      end
      if (strb.wrIntEn) intEn <= wdata[N_FLAG-1:0];
    end
  end

  // queue control
  assign flush    = strb.wrControl && wdata[2];
  assign txFull   = txFifoMode ? (txCount == CNT_W'(DEPTH)) : (txCount != '0);
  assign rxFull   = rxFifoMode ? (rxCount == CNT_W'(DEPTH)) : (rxCount != '0);
  assign rxEmpty  = (rxCount == '0);
  assign txValid  = globalOn && txOn && (txCount != '0);
  assign txPushOk = strb.wrData && !txFull;
  assign txPopOk  = txPop && txValid;
  assign rxAccept = rxPush && globalOn && rxOn;
  assign rxPushOk = rxAccept && !rxFull;
  assign rxMark   = rxAccept && rxFull;
  assign rxPopOk  = strb.rdData && !rxEmpty;
  assign txLowHit = (txCount <= CNT_W'(TX_LOW));
  assign rxHit    = (rxCount > CNT_W'(HALF) + CNT_W'(rxThresh));
  assign txIdle   = (txCount == '0) && !txBusy;

  sioFifo #(.WIDTH(REG_W), .DEPTH(DEPTH), .MARK_BIT(0)) txQueue (
    .clk(clk), .rstN(rstN), .flush(flush),
    .push(txPushOk), .pushData(wdata),
    .pop(txPopOk), .markLast(1'b0),
    .headData(txData), .count(txCount)
  );

  sioFifo #(.WIDTH(RX_ENTRY_W), .DEPTH(DEPTH), .MARK_BIT(RX_OVR_BIT)) rxQueue (
    .clk(clk), .rstN(rstN), .flush(flush),
    .push(rxPushOk), .pushData({rxOvrErr, rxFrmErr, rxParErr, rxData}),
    .pop(rxPopOk), .markLast(rxMark),
    .headData(rxHeadEntry), .count(rxCount)
  );

  // error flags of the character last taken from the receive queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        errLatch <= '0;
    else if (flush)   errLatch <= '0;
    else if (rxPopOk) errLatch <= rxHeadEntry[RX_ENTRY_W-1:REG_W];
  end

  // interrupt flags
  always_comb begin
    hwSet          = '0;
    hwSet[FLAG_TX] = txLowHit;
    hwSet[FLAG_RX] = rxHit;
    swSet          = strb.wrFlagSet ? wdata[N_FLAG-1:0] : '0;
    swClr          = strb.wrFlagClr ? wdata[N_FLAG-1:0] : '0;
  end

  for (genvar i = 0; i < N_FLAG; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= (flags[i] && !swClr[i]) || hwSet[i] || swSet[i];
    end
  end

  assign irq = |(flags & intEn);

  // outputs to the shift logic
  assign cfgEightBit  = frEight;
  assign cfgTwoStop   = frTwoStop;
  assign cfgParityOn  = frParOn;
  assign cfgParityOdd = frParOdd;
  assign cfgRxOn      = rxOn;
  assign cfgTxOn      = txOn;
  assign baudDiv      = {divHi, divLo};

  // register view for the read mux
  always_comb begin
    view          = '0;
    view.enable   = {{(REG_W-1){1'b0}}, globalOn};
    view.control  = {{(REG_W-2){1'b0}}, txOn, rxOn};
    view.line     = {1'b0, txIdle, 3'b000, errLatch};
    view.frame    = {3'b000, frParOdd, 1'b0, frParOn, frTwoStop, frEight};
    view.divLo    = divLo;
    view.divHi    = divHi;
    view.fifoStat = {txLowHit, 2'b00, txFull, rxHit, rxEmpty, 2'b00};
    view.fifoCfg  = {txFifoMode, 3'b000, rxFifoMode, rxThresh};
    view.intEn    = {{(REG_W-N_FLAG){1'b0}}, intEn};
    view.intStat  = {{(REG_W-N_FLAG){1'b0}}, flags};
    view.rxHead   = rxEmpty ? '0 : rxHeadEntry[REG_W-1:0];
  end
endmodule

// File: rtl/sioRegUnit.sv
module sioRegUnit
  import sioPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [7:0]        busRdata,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txPop,
  input  logic              txBusy,
  input  logic              rxPush,
  input  logic [7:0]        rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              rxOvrErr,
  output logic              cfgEightBit,
  output logic              cfgTwoStop,
  output logic              cfgParityOn,
  output logic              cfgParityOdd,
  output logic              cfgRxOn,
  output logic              cfgTxOn,
  output logic [15:0]       baudDiv,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  strobes_t         strb;
  regView_t         view;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [1:0]       flags;
  logic [1:0]       intEnW;

  assign intEnW = view.intEn[1:0];

  sioCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .view(view), .strb(strb), .busRdata(busRdata)
  );

  sioDatapath #(.DEPTH(DEPTH), .TX_LOW(4), .N_FLAG(2)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .txPop(txPop), .txBusy(txBusy),
    .rxPush(rxPush), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxOvrErr(rxOvrErr),
    .view(view), .txValid(txValid), .txData(txData),
    .cfgEightBit(cfgEightBit), .cfgTwoStop(cfgTwoStop),
    .cfgParityOn(cfgParityOn), .cfgParityOdd(cfgParityOdd),
    .cfgRxOn(cfgRxOn), .cfgTxOn(cfgTxOn), .baudDiv(baudDiv),
    .irq(irq), .txCount(txCount), .rxCount(rxCount), .flags(flags)
  );
endmodule

// File: rtl/sioRegUnitChk.sv
module sioRegUnitChk #(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              busWe,
  input logic              txValid,
  input logic              irq,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic [1:0]        flags,
  input logic [1:0]        intEnW
);
  // R3
  tx_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(DEPTH));

  // R3
  tx_valid_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txCount != '0));

  // R6
  rx_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  // R9
  flag_set_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h1D) && busWdata[1]) |=> flags[1]);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEnW == 2'b00) |-> !irq);

  // R11
  soft_reset_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h01) && busWdata[2]) |=> (txCount == '0 && rxCount == '0));
endmodule

bind sioRegUnit sioRegUnitChk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
  .txValid(txValid), .irq(irq), .txCount(txCount), .rxCount(rxCount),
  .flags(flags), .intEnW(intEnW)
);

// File: tb/sioRegUnit_test.sv
module sioRegUnit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  localparam logic [4:0] A_EN = 5'h00, A_CTL = 5'h01, A_LINE = 5'h02, A_FRAME = 5'h03,
    A_DATA = 5'h04, A_DLO = 5'h08, A_DHI = 5'h09, A_FST = 5'h0A, A_FCFG = 5'h0B,
    A_CLR = 5'h1C, A_SET = 5'h1D, A_IEN = 5'h1E, A_IST = 5'h1F;

  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic busWe = 1'b0, busRe = 1'b0;
  logic txValid, txPop = 1'b0, txBusy = 1'b0;
  logic [7:0] txData;
  logic rxPush = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0, rxOvrErr = 1'b0;
  logic [7:0] rxData = '0;
  logic cfgEightBit, cfgTwoStop, cfgParityOn, cfgParityOdd, cfgRxOn, cfgTxOn, irq;
  logic [15:0] baudDiv;

  int nChecks = 0, nFails = 0;
  logic [7:0]  txQ[$];
  logic [10:0] rxQ[$];
  int txCap = DEPTH, rxCap = DEPTH;
  bit rxAcc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sioRegUnit uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRe(busRe), .busRdata(busRdata), .txValid(txValid), .txData(txData),
    .txPop(txPop), .txBusy(txBusy), .rxPush(rxPush), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxOvrErr(rxOvrErr),
    .cfgEightBit(cfgEightBit), .cfgTwoStop(cfgTwoStop), .cfgParityOn(cfgParityOn),
    .cfgParityOdd(cfgParityOdd), .cfgRxOn(cfgRxOn), .cfgTxOn(cfgTxOn),
    .baudDiv(baudDiv), .irq(irq)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lineExp(input logic [2:0] errs, input bit idle);
    return {24'd0, 1'b0, idle, 3'b000, errs};
  endfunction

  function automatic int fstatExp();
    bit txFull = (txQ.size() >= txCap);
    bit rxEmpty = (rxQ.size() == 0);
    return {24'd0, (txQ.size() <= 4), 2'b00, txFull, 1'b0, rxEmpty, 2'b00};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #1 busWe = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRe = 1'b1; #1 d = busRdata;
    @(posedge clk); #1 busRe = 0;
  endtask

  task automatic txWrite(input logic [7:0] d);
    busWrite(A_DATA, d);
    if (txQ.size() < txCap) txQ.push_back(d);
  endtask

  task automatic txTake(input string tag);
    @(negedge clk);
    chkEq({tag, " txValid"}, txValid, 1);
    chkEq({tag, " txData"}, txData, txQ[0]);
    txPop = 1'b1;
    @(posedge clk); #1 txPop = 1'b0;
    void'(txQ.pop_front());
  endtask

  task automatic rxSend(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk); rxPush = 1'b1; rxData = d; {rxOvrErr, rxFrmErr, rxParErr} = e;
    @(posedge clk); #1 rxPush = 1'b0;
    if (rxAcc) begin
      if (rxQ.size() < rxCap) rxQ.push_back({e, d});
      else rxQ[rxQ.size()-1][10] = 1'b1;
    end
  endtask

  task automatic rxTake(input string tag);
    logic [7:0] d;
    logic [10:0] e;
    e = rxQ.pop_front();
    busRead(A_DATA, d);
    chkEq({tag, " data"}, d, e[7:0]);
    busRead(A_LINE, d);
    chkEq({tag, " line"}, d, lineExp(e[10:8], txQ.size() == 0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tick();

    // R1 reset state
    chkEq("R1 irq", irq, 0);
    busRead(A_FST, r);  chkEq("R1 fifo status", r, 'h84);
    busRead(A_LINE, r); chkEq("R1 line status", r, 'h40);
    busRead(A_EN, r);   chkEq("R1 enable", r, 0);
    busRead(A_CTL, r);  chkEq("R1 control", r, 0);
    busRead(A_IST, r);  chkEq("R1 R8 int status", r, 'h01);

    // R2 configuration registers
    busWrite(A_FRAME, 8'hFF);
    busRead(A_FRAME, r); chkEq("R2 frame readback", r, 'h17);
    chkEq("R2 frame outputs", {cfgEightBit, cfgTwoStop, cfgParityOn, cfgParityOdd}, 'hF);
    busWrite(A_FRAME, 8'h01);
    chkEq("R2 frame outputs 8N1", {cfgEightBit, cfgTwoStop, cfgParityOn, cfgParityOdd}, 'h8);
    busWrite(A_DLO, 8'h34); busWrite(A_DHI, 8'h12);
    chkEq("R2 baudDiv", baudDiv, 'h1234);
    busRead(A_DHI, r); chkEq("R2 div high", r, 'h12);
    busWrite(A_CTL, 8'h03);
    busRead(A_CTL, r); chkEq("R2 control", r, 'h03);
    chkEq("R2 enables out", {cfgRxOn, cfgTxOn}, 3);

    busWrite(A_EN, 8'h01);
    busWrite(A_FCFG, 8'h88);
    rxAcc = 1'b1;

    // R3 transmit ordering and overflow drop, random bytes
    for (int i = 0; i < DEPTH + 4; i++) txWrite(8'($urandom));
    busRead(A_FST, r);  chkEq("R3 fifo status full", r, fstatExp());
    busRead(A_LINE, r); chkEq("R12 line busy queue", r, lineExp(3'b0, 0));
    while (txQ.size() > 0) txTake("R3 pop");
    @(negedge clk); chkEq("R3 txValid empty", txValid, 0);

    // R8 transmit low-water flag
    for (int i = 0; i < 5; i++) txWrite(8'($urandom));
    busWrite(A_CLR, 8'h01);
    busRead(A_IST, r); chkEq("R8 tx flag above low", r & 1, 0);
    busRead(A_FST, r); chkEq("R8 fifo bit7 above low", r & 'h80, 0);
    txTake("R8 pop");
    tick();
    busRead(A_IST, r); chkEq("R8 tx flag at four", r & 1, 1);
    busRead(A_FST, r); chkEq("R8 fifo bit7 at four", r & 'h80, 'h80);
    while (txQ.size() > 0) txTake("R8 drain");
    busWrite(A_CLR, 8'h01);
    busRead(A_IST, r); chkEq("R9 hw set beats clear", r & 1, 1);

    // R5 receive with random error flags
    for (int i = 0; i < 6; i++) rxSend(8'($urandom), 3'($urandom));
    while (rxQ.size() > 0) rxTake("R5 rx");
    busWrite(A_EN, 8'h00); rxAcc = 1'b0;
    rxSend(8'hA5, 3'b000);
    busWrite(A_EN, 8'h01); rxAcc = 1'b1;
    busRead(A_FST, r); chkEq("R5 push ignored when disabled", r, fstatExp());

    // R7 threshold above half plus setting
    for (int i = 0; i < 8; i++) rxSend(8'($urandom), 3'b000);
    tick();
    busRead(A_FST, r); chkEq("R7 eight entries", r & 'h08, 0);
    busRead(A_IST, r); chkEq("R7 rx flag at eight", r & 2, 0);
    rxSend(8'($urandom), 3'b000);
    tick();
    busRead(A_FST, r); chkEq("R7 nine entries", r & 'h08, 'h08);
    busRead(A_IST, r); chkEq("R7 rx flag at nine", r & 2, 2);
    busWrite(A_FCFG, 8'h8F);
    busRead(A_FST, r); chkEq("R7 thresh7 nine", r & 'h08, 0);
    for (int i = 0; i < 7; i++) rxSend(8'($urandom), 3'($urandom) & 3'b011);
    busRead(A_FST, r); chkEq("R7 thresh7 full", r & 'h08, 'h08);

    // R6 overflow marks newest stored entry
    rxSend(8'hEE, 3'b000);
    rxSend(8'hDD, 3'b000);
    while (rxQ.size() > 0) rxTake("R6 rx");
    busWrite(A_FCFG, 8'h88);

    // R9 R10 set/clear and masking
    busWrite(A_CLR, 8'h03);
    busWrite(A_IEN, 8'h02);
    chkEq("R10 irq masked tx", irq, 0);
    busWrite(A_SET, 8'h02);
    chkEq("R9 set raises irq", irq, 1);
    busRead(A_IST, r); chkEq("R10 status both", r, 'h03);
    busWrite(A_CLR, 8'h02);
    chkEq("R9 clear drops irq", irq, 0);
    busWrite(A_IEN, 8'h01);
    chkEq("R10 tx enabled irq", irq, 1);
    busWrite(A_IEN, 8'h00);
    chkEq("R10 all masked", irq, 0);

    // R11 soft reset
    for (int i = 0; i < 3; i++) txWrite(8'($urandom));
    rxSend(8'h5A, 3'b111);
    rxSend(8'h3C, 3'b000);
    rxTake("R11 pre");
    busWrite(A_CTL, 8'h07);
    txQ.delete(); rxQ.delete();
    busRead(A_FST, r);  chkEq("R11 queues flushed", r, 'h84);
    busRead(A_LINE, r); chkEq("R11 errors cleared", r, 'h40);
    busRead(A_CTL, r);  chkEq("R11 control bit2 reads 0", r, 'h03);
    @(negedge clk); chkEq("R11 txValid", txValid, 0);

    // R4 single-entry mode
    busWrite(A_FCFG, 8'h00); txCap = 1; rxCap = 1;
    txWrite(8'h11); txWrite(8'h22);
    busRead(A_FST, r); chkEq("R4 tx single full", r, 'h94);
    txTake("R4 tx");
    @(negedge clk); chkEq("R4 tx second dropped", txValid, 0);
    rxSend(8'h77, 3'b000);
    rxSend(8'h88, 3'b000);
    rxTake("R4 R6 rx single");
    busRead(A_FST, r); chkEq("R4 rx empty after one", r & 'h04, 'h04);

    // R12 idle needs shifter idle
    @(negedge clk); txBusy = 1'b1;
    busRead(A_LINE, r); chkEq("R12 shifter busy", r, 'h04);
    @(negedge clk); txBusy = 1'b0;
    busRead(A_LINE, r); chkEq("R12 shifter idle", r, 'h44);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule